// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel with Per-Byte Error Queue

This block takes a serial line, finds character frames on it with 16x oversampling, and turns each frame into a byte. Each byte goes into a small receive queue. Every slot in the queue holds the byte together with its own error record and a multiprocessor address bit. The CPU side always sees the head slot and removes it with a one-cycle pop strobe. The 16x sampling tick comes from outside the block, from a baud generator that is not part of this design.

The block also holds the receive-enable and transmit-enable control bits. Three events force the channel into a clean state: reset, an I/O-stop request, and carrier loss while the carrier auto-enable option is on. Each of them empties the queue, erases every stored error flag, and clears both enable bits. When auto-enable is off, the carrier input is ignored.

Frame layout on the line: a low start bit, then DATA_W data bits with the least significant bit first, then an optional parity bit, then an optional address bit, then one high stop bit.

Top module: `uart_rx_chan`

## Requirements
- R1: After reset the queue is empty (`rx_count` = 0), both enable bits are 0, and the head fields read all zero.
- R2: With one `tick16` per bit-sixteenth, a low level must still be present 7 ticks after it was first seen before it counts as a start bit. A low pulse shorter than that produces no byte. Each following bit is sampled 16 ticks after the previous sample, and the byte is assembled least significant bit first.
- R3: When parity is enabled, `head_err` bit 0 is set if the XOR of the data bits and the parity bit differs from `par_odd`. The check therefore uses even parity when `par_odd` = 0 and odd parity when `par_odd` = 1.
- R4: A stop bit sampled low on a frame that is not a break sets `head_err` bit 1 (framing).
- R5: The queue holds DEPTH entries (default 4). A byte that completes while the queue is full and no pop happens in the same cycle is discarded, and `head_err` bit 2 (overrun) is set on the newest stored entry.
- R6: A frame whose data, parity, address and stop positions are all zero is stored as exactly one entry: data 0, `head_err` = 4'b1000 (bit 3, break). No further entry is made until the line has returned high.
- R7: When address mode (`mp_en`) is on, the bit that follows the data (and the parity bit, if present) is stored per entry and shown on `head_mp`. With address mode off, `head_mp` is 0.
- R8: A pop on a non-empty queue removes the head entry, and entries leave in arrival order. A pop on an empty queue changes nothing, and the head fields keep showing the last entry popped.
- R9: A write on `ctrl_wr` loads receive enable from `ctrl_wdata` bit 6 and transmit enable from bit 5 one clock later. While receive enable is 0, line activity stores nothing.
- R10: `io_stop` high for one clock empties the queue, zeroes every queued error flag and the head fields, and clears both enable bits by the next clock. This takes priority over a control write in the same cycle.
- R11: With `cd_auto` = 1, `cd_line` high has the same effect as R10.
- R12: With `cd_auto` = 0, `cd_line` affects neither the queue nor the enable bits, and frames are still received while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | Sampling tick, 16 per bit time |
| par_en | input | 1 | Parity bit present in frame |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| mp_en | input | 1 | Address bit present in frame |
| cd_line | input | 1 | Carrier detect, high means carrier lost |
| cd_auto | input | 1 | Carrier auto-enable option |
| io_stop | input | 1 | I/O stop request |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte (bit 6 receive enable, bit 5 transmit enable) |
| pop | input | 1 | Remove head entry |
| rx_en | output | 1 | Receive enable bit |
| tx_en | output | 1 | Transmit enable bit |
| head_data | output | DATA_W | Head entry byte |
| head_err | output | 4 | Head entry flags: 3 break, 2 overrun, 1 framing, 0 parity |
| head_mp | output | 1 | Head entry address bit |
| rx_count | output | clog2(DEPTH+1) | Number of queued entries |

## Verification
The enable bits and the queue react one clock after a control write, a pop, `io_stop` or carrier loss. The bench drives those inputs on a falling edge, updates its model right after the next rising edge, and compares on the falling edge that follows. A received byte is stored about two clocks after the stop-bit sample, which happens near the middle of the stop bit. For that reason the queue comparison is paused while a frame is on the line. The expected entry is added to the model 12 clocks after the stop bit ends, and the comparison resumes from then on.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  // per-entry error record, bit 0 parity .. bit 3 break
  typedef struct packed {
    logic brk;
    logic ovr;
    logic frm;
    logic par;
  } rx_err_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rx_state_t;

  localparam int RXEN_BIT = 6;
  localparam int TXEN_BIT = 5;
endpackage

// File: rtl/uart_rxq_deser.sv
module uart_rxq_deser
  import uart_rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              mp_en,
  output logic              done,
  output logic [DATA_W-1:0] dout,
  output rx_err_t           err,
  output logic              mp
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W + 4);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 2);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [1:0]        sync_q;
  logic              rx_s;
  rx_state_t         st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [IW-1:0]     idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              par_q, par_n, mp_q, mp_n, done_q, done_n;
  rx_err_t           err_q, err_n;
  logic [IW-1:0]     par_idx, mp_idx, stop_idx;
  logic              brk_w, par_bad;

  assign rx_s     = sync_q[1];
  assign par_idx  = IW'(DATA_W);
  assign mp_idx   = IW'(DATA_W) + IW'(par_en);
  assign stop_idx = IW'(DATA_W) + IW'(par_en) + IW'(mp_en);
  assign brk_w    = (sh_q == '0) && !par_q && !mp_q && !rx_s;
  assign par_bad  = par_en && ((^sh_q ^ par_q) != par_odd);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    par_n  = par_q;
    mp_n   = mp_q;
    err_n  = err_q;
    done_n = 1'b0;
    if (!enable) begin
      st_n  = RX_IDLE;
      cnt_n = '0;
      idx_n = '0;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: if (!rx_s) begin
          st_n  = RX_START;
          cnt_n = '0;
        end
        RX_START: if (cnt_q == MID) begin
          st_n  = rx_s ? RX_IDLE : RX_BITS;
          cnt_n = '0;
          idx_n = '0;
          par_n = 1'b0;
          mp_n  = 1'b0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
        RX_BITS: if (cnt_q == LAST) begin
          cnt_n = '0;
          idx_n = idx_q + 1'b1;
          if (idx_q < IW'(DATA_W)) sh_n = {rx_s, sh_q[DATA_W-1:1]};
          else if (par_en && idx_q == par_idx) par_n = rx_s;
          else if (mp_en && idx_q == mp_idx) mp_n = rx_s;
          if (idx_q == stop_idx) begin
            done_n = 1'b1;
            err_n  = brk_w ? '{brk: 1'b1, ovr: 1'b0, frm: 1'b0, par: 1'b0}
                           : '{brk: 1'b0, ovr: 1'b0, frm: !rx_s, par: par_bad};
            st_n   = rx_s ? RX_IDLE : RX_HOLD;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
        default: if (rx_s) st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      mp_q   <= 1'b0;
      err_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      par_q  <= par_n;
      mp_q   <= mp_n;
      err_q  <= err_n;
      done_q <= done_n;
    end
  end

  assign done = done_q;
  assign dout = sh_q;
  assign err  = err_q;
  assign mp   = mp_q;

  // R2: a character completes at most once per frame
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R6: a break record carries no other flag and a zero byte
  a_r6_break_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q.brk) |-> (sh_q == '0 && !err_q.frm && !err_q.par));
endmodule

// File: rtl/uart_rxq_fifo.sv
module uart_rxq_fifo
  import uart_rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4   // power of two, at least 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DATA_W-1:0]          wdata,
  input  rx_err_t                    werr,
  input  logic                       wmp,
  input  logic                       pop,
  output logic [DATA_W-1:0]          rdata,
  output rx_err_t                    rerr,
  output logic                       rmp,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW      = $clog2(DEPTH);
  localparam int CNTW    = $clog2(DEPTH + 1);
  localparam int EW      = DATA_W + 5;
  localparam int OVR_POS = DATA_W + 2;

  logic [EW-1:0]   ent_q [DEPTH];
  logic [EW-1:0]   ent_n [DEPTH];
  logic [AW-1:0]   wr_q, wr_n, rd_q, rd_n, newest, head_idx;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic            full, do_pop, do_push, ovr;

  assign full     = (cnt_q == CNTW'(DEPTH));
  assign do_pop   = pop && (cnt_q != '0);
  assign do_push  = push && (!full || do_pop);
  assign ovr      = push && full && !do_pop;
  assign newest   = wr_q - AW'(1);
  assign head_idx = (cnt_q == '0) ? rd_q - AW'(1) : rd_q;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    for (int i = 0; i < DEPTH; i++) ent_n[i] = ent_q[i];
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
      for (int i = 0; i < DEPTH; i++) ent_n[i] = '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (do_push && wr_q == AW'(i)) ent_n[i] = {wmp, werr, wdata};
        else if (ovr && newest == AW'(i)) ent_n[i][OVR_POS] = 1'b1;
      end
      if (do_push) wr_n = wr_q + 1'b1;
      if (do_pop)  rd_n = rd_q + 1'b1;
      cnt_n = cnt_q + CNTW'(do_push) - CNTW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
    end
  end

  assign {rmp, rerr, rdata} = ent_q[head_idx];
  assign count = cnt_q;

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(DEPTH));
  a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (cnt_q == CNTW'(DEPTH)));
  a_r8_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt_q == '0 && !push && !flush) |=> (cnt_q == '0 && $stable(rdata) && $stable(rerr)));
  a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0 && rerr == '0));
endmodule

// File: rtl/uart_rx_chan.sv
module uart_rx_chan
  import uart_rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int OVS    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rxd,
  input  logic                       tick16,
  input  logic                       par_en,
  input  logic                       par_odd,
  input  logic                       mp_en,
  input  logic                       cd_line,
  input  logic                       cd_auto,
  input  logic                       io_stop,
  input  logic                       ctrl_wr,
  input  logic [7:0]                 ctrl_wdata,
  input  logic                       pop,
  output logic                       rx_en,
  output logic                       tx_en,
  output logic [DATA_W-1:0]          head_data,
  output logic [3:0]                 head_err,
  output logic                       head_mp,
  output logic [$clog2(DEPTH+1)-1:0] rx_count
);
  logic              flush, rx_en_q, rx_en_n, tx_en_q, tx_en_n;
  logic              ch_done, ch_mp;
  logic [DATA_W-1:0] ch_data;
  rx_err_t           ch_err, hd_err;

  assign flush = io_stop || (cd_auto && cd_line);

  always_comb begin
    rx_en_n = rx_en_q;
    tx_en_n = tx_en_q;
    if (flush) begin
      rx_en_n = 1'b0;
      tx_en_n = 1'b0;
    end else if (ctrl_wr) begin
      rx_en_n = ctrl_wdata[RXEN_BIT];
      tx_en_n = ctrl_wdata[TXEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
    end else begin
      rx_en_q <= rx_en_n;
      tx_en_q <= tx_en_n;
    end
  end

  uart_rxq_deser #(.DATA_W(DATA_W), .OVS(OVS)) u_deser (
    .clk(clk), .rst_n(rst_n), .enable(rx_en_q), .tick(tick16), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .mp_en(mp_en),
    .done(ch_done), .dout(ch_data), .err(ch_err), .mp(ch_mp)
  );

  uart_rxq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(ch_done && rx_en_q),
    .wdata(ch_data), .werr(ch_err), .wmp(ch_mp), .pop(pop),
    .rdata(head_data), .rerr(hd_err), .rmp(head_mp), .count(rx_count)
  );

  assign head_err = hd_err;
  assign rx_en    = rx_en_q;
  assign tx_en    = tx_en_q;

  a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    io_stop |=> (!rx_en && !tx_en && rx_count == '0));
  a_r11_cd_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_auto && cd_line) |=> (!rx_en && !tx_en && rx_count == '0));
  a_r12_cd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cd_auto && !io_stop && !ctrl_wr) |=> (rx_en == $past(rx_en) && tx_en == $past(tx_en)));
  a_r9_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !flush) |=> (rx_en == $past(ctrl_wdata[6]) && tx_en == $past(ctrl_wdata[5])));
endmodule

// File: tb/sim_uart_rx_chan.sv
module sim_uart_rx_chan;
  localparam int CLK_P    = 10;
  localparam int DW       = 8;
  localparam int DEP      = 4;
  localparam int BIT_CLKS = 16;

  logic       clk, rst_n, rxd, tick16, par_en, par_odd, mp_en;
  logic       cd_line, cd_auto, io_stop, ctrl_wr, pop;
  logic [7:0] ctrl_wdata;
  logic       rx_en, tx_en, head_mp;
  logic [DW-1:0] head_data;
  logic [3:0] head_err;
  logic [2:0] rx_count;

  uart_rx_chan #(.DATA_W(DW), .DEPTH(DEP), .OVS(16)) u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .par_en(par_en),
    .par_odd(par_odd), .mp_en(mp_en), .cd_line(cd_line), .cd_auto(cd_auto),
    .io_stop(io_stop), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .pop(pop),
    .rx_en(rx_en), .tx_en(tx_en), .head_data(head_data), .head_err(head_err),
    .head_mp(head_mp), .rx_count(rx_count)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  // reference model: entries are {mp, brk, ovr, frm, par, data}
  logic [12:0] mq[$];
  logic [12:0] last_head;
  bit m_rx, m_tx, busy, mon_on, finished;
  int n_chk, n_fail;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] head_exp();
    return (mq.size() > 0) ? mq[0] : last_head;
  endfunction

  always @(negedge clk) begin
    if (mon_on && !finished) begin
      chk(rx_en == m_rx, "R9 rx_en vs model", 32'(rx_en), 32'(m_rx));
      chk(tx_en == m_tx, "R9 tx_en vs model", 32'(tx_en), 32'(m_tx));
      if (!busy) begin
        chk(rx_count == 3'(mq.size()), "R8 count vs model", 32'(rx_count), 32'(mq.size()));
        chk({head_mp, head_err, head_data} == head_exp(), "R8 head vs model",
            32'({head_mp, head_err, head_data}), 32'(head_exp()));
      end
    end
  end

  function automatic logic [12:0] frame_entry(logic [7:0] d, bit p, bit mp, bit stop);
    bit pe = par_en, me = mp_en, po = par_odd;
    bit brk = (d == 8'h00) && !(pe && p) && !(me && mp) && !stop;
    bit perr;
    if (brk) return {1'b0, 4'b1000, 8'h00};
    perr = pe && ((^d ^ p) != po);
    return {me & mp, 1'b0, 1'b0, !stop, perr, d};
  endfunction

  task automatic model_push(input logic [12:0] e);
    if (!m_rx) return;
    if (mq.size() == DEP) mq[DEP-1][10] = 1'b1;
    else mq.push_back(e);
  endtask

  task automatic send_bit(input bit b);
    rxd = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit p, input bit mp, input bit stop);
    busy = 1'b1;
    send_bit(1'b0);
    for (int i = 0; i < DW; i++) send_bit(d[i]);
    if (par_en) send_bit(p);
    if (mp_en) send_bit(mp);
    send_bit(stop);
    rxd = 1'b1;
    repeat (12) @(negedge clk);
    model_push(frame_entry(d, p, mp, stop));
    busy = 1'b0;
  endtask

  task automatic ctrl_write(input logic [7:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    @(posedge clk); #1;
    m_rx = v[6]; m_tx = v[5];
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic pop_one(input string tag);
    chk({head_mp, head_err, head_data} == head_exp(), tag,
        32'({head_mp, head_err, head_data}), 32'(head_exp()));
    pop = 1'b1;
    @(posedge clk); #1;
    if (mq.size() > 0) last_head = mq.pop_front();
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic model_flush();
    mq.delete();
    last_head = '0;
    m_rx = 1'b0;
    m_tx = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; tick16 = 1'b1; par_en = 1'b0; par_odd = 1'b0; mp_en = 1'b0;
    cd_line = 1'b0; cd_auto = 1'b0; io_stop = 1'b0; ctrl_wr = 1'b0; ctrl_wdata = '0; pop = 1'b0;
    last_head = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rx_count == 0 && !rx_en && !tx_en, "R1 reset count/enables", 32'({rx_count, rx_en, tx_en}), 0);
    chk({head_mp, head_err, head_data} == 0, "R1 reset head", 32'({head_mp, head_err, head_data}), 0);
    mon_on = 1'b1;

    // R9 receiver off: frame ignored
    send_frame(8'h33, 1'b0, 1'b0, 1'b1);
    chk(rx_count == 0, "R9 disabled receiver stores nothing", 32'(rx_count), 0);
    ctrl_write(8'h60);
    chk(rx_en && tx_en, "R9 enables loaded from bits 6 and 5", 32'({rx_en, tx_en}), 3);
    ctrl_write(8'h40);
    chk(rx_en && !tx_en, "R9 only bit 6 set", 32'({rx_en, tx_en}), 2);
    ctrl_write(8'h60);

    // R2 plain frames
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
    chk(rx_count == 2 && head_data == 8'hA5 && head_err == 0, "R2 two bytes queued, first at head",
        32'({rx_count, head_data}), 32'({3'd2, 8'hA5}));
    // R2 short low glitch is no start bit
    busy = 1'b1;
    rxd = 1'b0; repeat (4) @(negedge clk);
    rxd = 1'b1; repeat (40) @(negedge clk);
    busy = 1'b0;
    chk(rx_count == 2, "R2 glitch rejected", 32'(rx_count), 2);

    // R8 ordering and empty pop
    pop_one("R8 pop first");
    pop_one("R8 pop second");
    chk(rx_count == 0 && head_data == 8'h3C, "R8 empty shows last head", 32'({rx_count, head_data}), 32'({3'd0, 8'h3C}));
    pop_one("R8 pop on empty");
    chk(rx_count == 0 && head_data == 8'h3C, "R8 empty pop no effect", 32'({rx_count, head_data}), 32'({3'd0, 8'h3C}));

    // R3 parity, even then odd
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
    send_frame(8'h5A, 1'b1, 1'b0, 1'b1);
    par_odd = 1'b1;
    send_frame(8'h5A, 1'b1, 1'b0, 1'b1);
    send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
    chk(head_err == 4'b0000, "R3 even parity good", 32'(head_err), 0);
    pop_one("R3 even good");
    chk(head_err == 4'b0001, "R3 even parity bad", 32'(head_err), 1);
    pop_one("R3 even bad");
    chk(head_err == 4'b0000, "R3 odd parity good", 32'(head_err), 0);
    pop_one("R3 odd good");
    chk(head_err == 4'b0001, "R3 odd parity bad", 32'(head_err), 1);
    pop_one("R3 odd bad");
    par_en = 1'b0; par_odd = 1'b0;

    // R4 framing, R6 break
    send_frame(8'h81, 1'b0, 1'b0, 1'b0);
    send_frame(8'h00, 1'b0, 1'b0, 1'b0);
    chk(rx_count == 2, "R6 break stored once", 32'(rx_count), 2);
    chk(head_err == 4'b0010 && head_data == 8'h81, "R4 framing flag", 32'({head_err, head_data}), 32'({4'b0010, 8'h81}));
    pop_one("R4 framing entry");
    chk(head_err == 4'b1000 && head_data == 8'h00, "R6 break entry", 32'({head_err, head_data}), 32'({4'b1000, 8'h00}));
    pop_one("R6 break entry");

    // R7 address bit
    mp_en = 1'b1;
    send_frame(8'h12, 1'b0, 1'b1, 1'b1);
    send_frame(8'h34, 1'b0, 1'b0, 1'b1);
    chk(head_mp && head_data == 8'h12, "R7 address bit set", 32'({head_mp, head_data}), 32'({1'b1, 8'h12}));
    pop_one("R7 first");
    chk(!head_mp && head_data == 8'h34, "R7 address bit clear", 32'({head_mp, head_data}), 32'({1'b0, 8'h34}));
    pop_one("R7 second");
    mp_en = 1'b0;

    // R5 overrun
    for (int k = 0; k < 5; k++) send_frame(8'(8'h10 + k), 1'b0, 1'b0, 1'b1);
    chk(rx_count == 4, "R5 queue full, fifth dropped", 32'(rx_count), 4);
    for (int k = 0; k < 3; k++) pop_one("R5 drain");
    chk(head_data == 8'h13 && head_err == 4'b0100, "R5 overrun on newest", 32'({head_err, head_data}), 32'({4'b0100, 8'h13}));
    pop_one("R5 last");

    // R10 io_stop flush with queued errors
    send_frame(8'h77, 1'b0, 1'b0, 1'b0);
    send_frame(8'h66, 1'b0, 1'b0, 1'b1);
    io_stop = 1'b1; ctrl_wr = 1'b1; ctrl_wdata = 8'h60;
    @(posedge clk); #1; model_flush();
    @(negedge clk); io_stop = 1'b0; ctrl_wr = 1'b0;
    chk(rx_count == 0 && head_err == 0 && !rx_en && !tx_en, "R10 stop flush",
        32'({rx_count, head_err, rx_en, tx_en}), 0);

    // R12 carrier ignored without auto
    ctrl_write(8'h60);
    cd_line = 1'b1;
    send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
    chk(rx_count == 1 && rx_en && tx_en, "R12 carrier ignored", 32'({rx_count, rx_en, tx_en}), 32'({3'd1, 2'b11}));
    send_frame(8'h00, 1'b0, 1'b0, 1'b0);
    // R11 auto carrier flush
    cd_auto = 1'b1;
    @(posedge clk); #1; model_flush();
    @(negedge clk); cd_line = 1'b0;
    chk(rx_count == 0 && head_err == 0 && !rx_en && !tx_en, "R11 carrier flush",
        32'({rx_count, head_err, rx_en, tx_en}), 0);
    repeat (5) @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule